// File: doc/BRIEF.md
# USART Bit-Clock Generator

This block turns the system clock into the timing strobes a serial transmitter and receiver need. A 12-bit programmable divisor drives a down-counting prescaler whose terminal count is the base tick, one cycle long, once every divisor + 1 system cycles. The mode inputs then decide what the base tick becomes.

In the two asynchronous modes the receiver gets an oversampling tick on every base tick. The transmitter gets a bit tick on every 16th base tick, or on every 8th when double speed is selected. In synchronous master mode the base tick toggles a serial clock that the block drives out. In synchronous slave mode an external serial clock is synchronized and edge-detected instead.

In both synchronous modes the block marks each serial-clock edge as either a change edge, where transmit data moves, or a sample edge, where receive data is taken. A polarity input picks which edge direction is the change edge. Shift registers, framing and data recovery sit outside the block.

Top module: `usart_clkgen`

## Requirements
- R1: While `rstN` is low, `xckOut`, `rxOvsTick`, `txBitTick`, `syncSampleStb` and `syncChangeStb` are all 0.
- R2: In asynchronous normal mode (`syncMode`=0, `doubleSpeed`=0), `rxOvsTick` pulses for one cycle every divisor + 1 cycles, for divisor values from 0 to 4095.
- R3: In asynchronous normal mode, `txBitTick` pulses every 16 × (divisor + 1) cycles, and every `txBitTick` coincides with a `rxOvsTick`.
- R4: In asynchronous double-speed mode (`syncMode`=0, `doubleSpeed`=1), `rxOvsTick` keeps the period divisor + 1 and `txBitTick` pulses every 8 × (divisor + 1) cycles.
- R5: A cycle with `divisorWr`=1 reloads the prescaler from `divisor` at once. The first `rxOvsTick` after the write is seen divisor + 1 cycles after the write edge, and none is seen before it.
- R6: In synchronous master mode (`syncMode`=1, `masterMode`=1), `xckOe` is 1 and `xckOut` holds each level for divisor + 1 cycles, giving a period of 2 × (divisor + 1).
- R7: In master mode with `changeOnFalling`=0, `syncChangeStb` is high in the cycle that `xckOut` first shows 1, and `syncSampleStb` in the cycle that it first shows 0. With `changeOnFalling`=1 the two are swapped.
- R8: In synchronous slave mode (`syncMode`=1, `masterMode`=0), `xckOe` is 0. An `xckIn` edge set up before clock edge k yields its one-cycle strobe after edge k+1, which is a two-cycle latency, with edge direction mapped as in R7.
- R9: `doubleSpeed` has no effect in synchronous modes: the master serial clock period stays 2 × (divisor + 1).
- R10: In asynchronous modes `syncSampleStb`, `syncChangeStb` and `xckOe` stay 0. In synchronous modes `rxOvsTick` and `txBitTick` stay 0.
- R11: `syncSampleStb` and `syncChangeStb` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| divisor | input | 12 | Prescaler divisor, 0 to 4095 |
| divisorWr | input | 1 | One-cycle pulse that reloads the prescaler from `divisor` |
| syncMode | input | 1 | 1 = synchronous operation, 0 = asynchronous |
| masterMode | input | 1 | In synchronous operation: 1 = drive the serial clock, 0 = follow `xckIn` |
| doubleSpeed | input | 1 | Asynchronous only: 8 samples per bit instead of 16 |
| changeOnFalling | input | 1 | 0 = rising serial-clock edge is the change edge, 1 = falling edge is |
| xckIn | input | 1 | External serial clock (slave mode) |
| xckOut | output | 1 | Generated serial clock (master mode) |
| xckOe | output | 1 | Output enable for the serial clock pad |
| rxOvsTick | output | 1 | Receiver oversampling tick |
| txBitTick | output | 1 | Transmitter bit tick |
| syncSampleStb | output | 1 | Synchronous sample-edge strobe |
| syncChangeStb | output | 1 | Synchronous change-edge strobe |

## Verification
Every strobe comes out of a register. A base tick that is combinational in one cycle is therefore seen one edge later, together with the `xckOut` level it toggled. This puts the first tick after a divisor write divisor + 1 edges after that write, and a slave strobe two edges after `xckIn` moves. The bench drives inputs and samples outputs on the falling clock edge. It counts rising edges from the stimulus edge to the exact cycle each result is due, and checks that nothing shows earlier. Periods are taken as the distance between two consecutive pulses, so the arbitrary phase at which a measurement begins does not matter.

// File: rtl/usart_clkgen_pkg.sv
package usart_clkgen_pkg;

  typedef enum logic [1:0] {
    MODE_ASYNC_NORM,
    MODE_ASYNC_DBL,
    MODE_SYNC_MASTER,
    MODE_SYNC_SLAVE
  } clkMode_e;

  // Strobes from control to datapath, all valid within one cycle
  typedef struct packed {
    logic cntLoad;
    logic baseTick;
    logic subClr;
    logic subInc;
    logic xckToggle;
    logic xckClr;
    logic ovsTick;
    logic bitTick;
    logic sampleStb;
    logic changeStb;
  } clkStb_t;

endpackage

// File: rtl/usart_clkgen_ctrl.sv
module usart_clkgen_ctrl
  import usart_clkgen_pkg::*;
#(
  parameter int OVS_NORM = 16,
  parameter int OVS_DBL  = 8,
  parameter int SUB_W    = $clog2(OVS_NORM)
) (
  input  logic             divWr,
  input  logic             cntZero,
  input  logic [SUB_W-1:0] subCnt,
  input  logic             xckLevel,
  input  logic             xsNow,
  input  logic             xsPrev,
  input  logic             syncMode,
  input  logic             masterMode,
  input  logic             doubleSpeed,
  input  logic             changeOnFalling,
  output clkStb_t          stb
);

  localparam logic [SUB_W-1:0] LAST_NORM = SUB_W'(OVS_NORM - 1);
  localparam logic [SUB_W-1:0] LAST_DBL  = SUB_W'(OVS_DBL - 1);

  clkMode_e         mode;
  logic             isAsync;
  logic [SUB_W-1:0] lastSub;
  logic             atLast;
  logic             riseEv;
  logic             fallEv;

  always_comb begin
    if (syncMode) mode = masterMode ? MODE_SYNC_MASTER : MODE_SYNC_SLAVE;
    else          mode = doubleSpeed ? MODE_ASYNC_DBL : MODE_ASYNC_NORM;
  end

  always_comb begin
    isAsync = (mode == MODE_ASYNC_NORM) || (mode == MODE_ASYNC_DBL);
    lastSub = (mode == MODE_ASYNC_DBL) ? LAST_DBL : LAST_NORM;
    atLast  = (subCnt == lastSub);
    riseEv  = 1'b0;
    fallEv  = 1'b0;
    stb     = '0;

    stb.cntLoad  = divWr | cntZero;
    stb.baseTick = cntZero & ~divWr;
    stb.subInc   = stb.baseTick & isAsync;
    stb.subClr   = divWr | ~isAsync | (stb.subInc & atLast);
    stb.ovsTick  = stb.subInc;
    stb.bitTick  = stb.subInc & atLast;

    case (mode)
      MODE_SYNC_MASTER: begin
        stb.xckToggle = stb.baseTick;
        riseEv        = stb.baseTick & ~xckLevel;
        fallEv        = stb.baseTick & xckLevel;
      end
      MODE_SYNC_SLAVE: begin
        stb.xckClr = 1'b1;
        riseEv     = xsNow & ~xsPrev;
        fallEv     = ~xsNow & xsPrev;
      end
      default: stb.xckClr = 1'b1;
    endcase

    stb.changeStb = changeOnFalling ? fallEv : riseEv;
    stb.sampleStb = changeOnFalling ? riseEv : fallEv;
  end

endmodule

// File: rtl/usart_clkgen_dp.sv
module usart_clkgen_dp
  import usart_clkgen_pkg::*;
#(
  parameter int DIV_W = 12,
  parameter int SUB_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] divisor,
  input  logic             xckIn,
  input  clkStb_t          stb,
  output logic             cntZero,
  output logic [SUB_W-1:0] subCnt,
  output logic             xckLevel,
  output logic             xsNow,
  output logic             xsPrev,
  output logic             ovsTickQ,
  output logic             bitTickQ,
  output logic             sampleStbQ,
  output logic             changeStbQ
);

  logic [DIV_W-1:0] cnt;

  assign cntZero = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt        <= '0;
      subCnt     <= '0;
      xsNow      <= 1'b0;
      xsPrev     <= 1'b0;
      xckLevel   <= 1'b0;
      ovsTickQ   <= 1'b0;
      bitTickQ   <= 1'b0;
      sampleStbQ <= 1'b0;
      changeStbQ <= 1'b0;
    end else begin
      cnt <= stb.cntLoad ? divisor : cnt - 1'b1;

      if (stb.subClr)      subCnt <= '0;
      else if (stb.subInc) subCnt <= subCnt + 1'b1;

      xsNow  <= xckIn;
      xsPrev <= xsNow;

      if (stb.xckClr)         xckLevel <= 1'b0;
      else if (stb.xckToggle) xckLevel <= ~xckLevel;

      ovsTickQ   <= stb.ovsTick;
      bitTickQ   <= stb.bitTick;
      sampleStbQ <= stb.sampleStb;
      changeStbQ <= stb.changeStb;
    end
  end

endmodule

// File: rtl/usart_clkgen.sv
module usart_clkgen
  import usart_clkgen_pkg::*;
#(
  parameter int DIV_W    = 12,
  parameter int OVS_NORM = 16,
  parameter int OVS_DBL  = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] divisor,
  input  logic             divisorWr,
  input  logic             syncMode,
  input  logic             masterMode,
  input  logic             doubleSpeed,
  input  logic             changeOnFalling,
  input  logic             xckIn,
  output logic             xckOut,
  output logic             xckOe,
  output logic             rxOvsTick,
  output logic             txBitTick,
  output logic             syncSampleStb,
  output logic             syncChangeStb
);

  localparam int SUB_W = $clog2(OVS_NORM);

  clkStb_t          stb;
  logic             cntZero;
  logic [SUB_W-1:0] subCnt;
  logic             xsNow;
  logic             xsPrev;

  assign xckOe = syncMode & masterMode;

  usart_clkgen_ctrl #(
    .OVS_NORM(OVS_NORM), .OVS_DBL(OVS_DBL), .SUB_W(SUB_W)
  ) ctrl_i (
    .divWr(divisorWr), .cntZero(cntZero), .subCnt(subCnt),
    .xckLevel(xckOut), .xsNow(xsNow), .xsPrev(xsPrev),
    .syncMode(syncMode), .masterMode(masterMode),
    .doubleSpeed(doubleSpeed), .changeOnFalling(changeOnFalling),
    .stb(stb)
  );

  usart_clkgen_dp #(
    .DIV_W(DIV_W), .SUB_W(SUB_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .divisor(divisor), .xckIn(xckIn), .stb(stb),
    .cntZero(cntZero), .subCnt(subCnt), .xckLevel(xckOut),
    .xsNow(xsNow), .xsPrev(xsPrev),
    .ovsTickQ(rxOvsTick), .bitTickQ(txBitTick),
    .sampleStbQ(syncSampleStb), .changeStbQ(syncChangeStb)
  );

endmodule

// File: rtl/usart_clkgen_chk.sv
module usart_clkgen_chk (
  input logic clk,
  input logic rstN,
  input logic syncMode,
  input logic masterMode,
  input logic xckOut,
  input logic rxOvsTick,
  input logic txBitTick,
  input logic syncSampleStb,
  input logic syncChangeStb
);

  AST_STB_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(syncSampleStb && syncChangeStb)); // R11

  AST_BIT_ON_OVS: assert property (@(posedge clk) disable iff (!rstN)
    txBitTick |-> rxOvsTick); // R3

  AST_ASYNC_QUIET_SYNC: assert property (@(posedge clk) disable iff (!rstN)
    !syncMode |=> (!syncSampleStb && !syncChangeStb)); // R10

  AST_SYNC_QUIET_ASYNC: assert property (@(posedge clk) disable iff (!rstN)
    syncMode |=> (!rxOvsTick && !txBitTick)); // R10

  AST_XCK_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !(syncMode && masterMode) |=> !xckOut); // R6

  AST_MASTER_CHANGE_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    (syncMode && masterMode) |=> (syncChangeStb -> (xckOut != $past(xckOut)))); // R7

endmodule

bind usart_clkgen usart_clkgen_chk chk_i (
  .clk(clk), .rstN(rstN), .syncMode(syncMode), .masterMode(masterMode),
  .xckOut(xckOut), .rxOvsTick(rxOvsTick), .txBitTick(txBitTick),
  .syncSampleStb(syncSampleStb), .syncChangeStb(syncChangeStb)
);

// File: tb/usart_clkgen_tb_top.sv
module usart_clkgen_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] divisor = '0;
  logic        divisorWr = 1'b0;
  logic        syncMode = 1'b0;
  logic        masterMode = 1'b0;
  logic        doubleSpeed = 1'b0;
  logic        changeOnFalling = 1'b0;
  logic        xckIn = 1'b0;
  logic        xckOut, xckOe, rxOvsTick, txBitTick, syncSampleStb, syncChangeStb;

  int nVec = 0;
  int nBad = 0;
  int cyc  = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  usart_clkgen dut_i (
    .clk(clk), .rstN(rstN), .divisor(divisor), .divisorWr(divisorWr),
    .syncMode(syncMode), .masterMode(masterMode), .doubleSpeed(doubleSpeed),
    .changeOnFalling(changeOnFalling), .xckIn(xckIn), .xckOut(xckOut),
    .xckOe(xckOe), .rxOvsTick(rxOvsTick), .txBitTick(txBitTick),
    .syncSampleStb(syncSampleStb), .syncChangeStb(syncChangeStb)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nVec++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic logic pick(input int sel);
    case (sel)
      0: return rxOvsTick;
      1: return txBitTick;
      2: return syncChangeStb;
      default: return syncSampleStb;
    endcase
  endfunction

  // distance in cycles between two consecutive pulses of a strobe
  task automatic gapOf(input int sel, input int limit, output int gap);
    int n;
    gap = -1;
    n = 0;
    while (!pick(sel) && n < limit) begin @(negedge clk); n++; end
    if (!pick(sel)) return;
    n = 0;
    do begin @(negedge clk); n++; end while (!pick(sel) && n < limit);
    if (pick(sel)) gap = n;
  endtask

  task automatic writeDiv(input int d);
    @(negedge clk);
    divisor = 12'(d); divisorWr = 1'b1;
    @(negedge clk);
    divisorWr = 1'b0;
  endtask

  task automatic setMode(input bit s, input bit m, input bit dbl, input bit pol);
    @(negedge clk);
    syncMode = s; masterMode = m; doubleSpeed = dbl; changeOnFalling = pol;
  endtask

  task automatic tReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    check(!xckOut && !rxOvsTick && !txBitTick && !syncSampleStb && !syncChangeStb,
          "R1", {xckOut, rxOvsTick, txBitTick, syncSampleStb, syncChangeStb}, 0);
    rstN = 1'b1;
  endtask

  task automatic tReload(input int d);
    int first;
    setMode(0, 0, 0, 0);
    writeDiv(d);
    first = -1;
    for (int k = 1; k <= d + 3; k++) begin
      @(negedge clk);
      if (rxOvsTick && first < 0) first = k;
    end
    check(first == d + 1, "R5", first, d + 1);
  endtask

  task automatic tAsync(input bit dbl, input int d);
    int g;
    int quiet;
    setMode(0, 0, dbl, 0);
    writeDiv(d);
    gapOf(0, 5000, g);
    check(g == d + 1, dbl ? "R4 ovs" : "R2", g, d + 1);
    gapOf(1, 70000, g);
    check(g == (dbl ? 8 : 16) * (d + 1), dbl ? "R4 bit" : "R3", g, (dbl ? 8 : 16) * (d + 1));
    check(rxOvsTick == 1'b1, "R3 bit on ovs", rxOvsTick, 1);
    quiet = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (syncSampleStb || syncChangeStb || xckOe) quiet++;
    end
    check(quiet == 0, "R10 async", quiet, 0);
  endtask

  task automatic tMaster(input bit pol, input bit dbl, input int d);
    int g;
    int n;
    int noisy;
    setMode(1, 1, dbl, pol);
    writeDiv(d);
    check(xckOe == 1'b1, "R6 oe", xckOe, 1);
    gapOf(2, 5000, g);
    check(g == 2 * (d + 1), dbl ? "R9" : "R6 period", g, 2 * (d + 1));
    check(xckOut == !pol, "R7 change level", xckOut, !pol);
    gapOf(3, 5000, g);
    check(xckOut == pol, "R7 sample level", xckOut, pol);
    // high phase length
    while (xckOut) @(negedge clk);
    while (!xckOut) @(negedge clk);
    n = 0;
    while (xckOut && n < 10000) begin @(negedge clk); n++; end
    check(n == d + 1, "R6 half period", n, d + 1);
    noisy = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (rxOvsTick || txBitTick || (syncSampleStb && syncChangeStb)) noisy++;
    end
    check(noisy == 0, "R10 sync / R11", noisy, 0);
  endtask

  task automatic tSlave(input bit pol);
    logic s1, s2, s3;
    setMode(1, 0, 0, pol);
    xckIn = 1'b0;
    repeat (4) @(negedge clk);
    check(xckOe == 1'b0, "R8 oe", xckOe, 0);
    xckIn = 1'b1;
    @(negedge clk); s1 = pol ? syncSampleStb : syncChangeStb;
    @(negedge clk); s2 = pol ? syncSampleStb : syncChangeStb;
    @(negedge clk); s3 = pol ? syncSampleStb : syncChangeStb;
    check(!s1 && s2 && !s3, "R8 rise latency", {s1, s2, s3}, 3'b010);
    xckIn = 1'b0;
    @(negedge clk); s1 = pol ? syncChangeStb : syncSampleStb;
    @(negedge clk); s2 = pol ? syncChangeStb : syncSampleStb;
    @(negedge clk); s3 = pol ? syncChangeStb : syncSampleStb;
    check(!s1 && s2 && !s3, "R8 fall latency", {s1, s2, s3}, 3'b010);
  endtask

  initial begin
    fork
      begin
        tReset();
        tReload(7);
        tReload(0);
        tAsync(0, 3);
        tAsync(0, 0);
        tAsync(1, 5);
        tMaster(0, 0, 2);
        tMaster(1, 0, 3);
        tMaster(0, 1, 2);
        tSlave(0);
        tSlave(1);
        tAsync(0, 4095);
      end
      begin
        wait (cyc >= 190000);
        check(0, "watchdog", cyc, 0);
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

endmodule